// File: doc/BRIEF.md
# Priority-Level Interrupt Mapping Controller

This block gathers eight level-sensitive interrupt request lines from peripherals and turns them into sixteen processor interrupt-priority-level lines. Each request position has a fixed priority level, set at build time by a packed parameter table. Two positions are tied to level zero. They are treated as unconnected and never become pending. For every pending request, the line for its level is driven high. When requests share a level, their contributions are OR-combined.

One byte-wide control register sits behind a minimal register port with select, write enable, write data and read data. A write stores the data with bit 6 forced to zero. A read returns the stored byte as it is. Bit 0 of the register is the global enable: while it is clear, every level line is held low, but the pending vector still tracks the inputs. The pending vector is available on a status port. The pending register and the level lines both update on the clock edge that samples a change on a request input or a register write.

Top module: `irq_level_mapper`

## Requirements
- R1: A request input at a mapped position makes its pending bit on `pending_o` follow the input level. The bit updates on the first clock edge after the input changes.
- R2: Request positions 0 and 6 map to level 0. They never set a pending bit and never raise any level line.
- R3: Request positions 1, 2, 3, 4, 5 and 7 drive level lines 1, 4, 6, 8, 10 and 14. Line n is bit n of `level_o`.
- R4: With several requests pending, `level_o` is the bitwise OR of the lines for all pending requests. Line 0 is never driven high.
- R5: While control bit 0 is 0, `level_o` is all zeros and `pending_o` still tracks the inputs. Setting the bit again restores the level lines on the next edge.
- R6: A write (`reg_sel_i` and `reg_we_i` both high at a clock edge) stores `reg_wdata_i & 8'hBF`. Bit 6 always reads back as 0.
- R7: `reg_rdata_o` always shows the stored control byte.
- R8: After reset, the control byte is 8'h01, `pending_o` is 0 and `level_o` is 0.
- R9: A write with `reg_sel_i` low changes nothing. Input changes and writes reach `level_o` on the first clock edge that samples them, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| irq_req_i | input | 8 | Level-sensitive interrupt requests |
| reg_sel_i | input | 1 | Control register select |
| reg_we_i | input | 1 | Write enable, qualified by select |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Stored control byte |
| level_o | output | 16 | Priority-level lines, bit n is level n |
| pending_o | output | 8 | Pending request vector |

## Verification
Each request position is first raised alone. This separates a correct table from one that is shifted or has swapped entries, and it shows that positions 0 and 6 stay silent. All-ones and mixed multi-bit patterns then test the OR combination. The same pattern is repeated with the enable bit cleared, which separates gating of the level lines from gating of the pending vector. A long pseudo-random run of requests and register writes, checked against a behavioural model on every clock, tests the one-edge latency and the write mask under arbitrary interleavings.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;
   // Packed level table, entry i at bits [4*i +: 4]: 0,1,4,6,8,10,0,14
   localparam logic [31:0] DEF_LVL_MAP = 32'hE0A8_6410;
   localparam logic [7:0]  DEF_WMASK   = 8'hBF;
   localparam logic [7:0]  DEF_CTRL_RST = 8'h01;

   typedef enum logic { OUT_COMB = 1'b0, OUT_FLOP = 1'b1 } out_style_e;
endpackage

// File: rtl/irqmap_ctrl_reg.sv
module irqmap_ctrl_reg #(
   parameter int          DW      = 8,
   parameter logic [DW-1:0] WMASK = 8'hBF,
   parameter logic [DW-1:0] RST_VAL = 8'h01
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          sel_i,
   input  logic          we_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] ctrl_d_o,
   output logic [DW-1:0] ctrl_q_o
);
   logic wr_hit;
   assign wr_hit = sel_i & we_i;

   always_comb begin
      ctrl_d_o = ctrl_q_o;
      if (wr_hit) ctrl_d_o = wdata_i & WMASK;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) ctrl_q_o <= RST_VAL;
      else       ctrl_q_o <= ctrl_d_o;
   end
endmodule

// File: rtl/irqmap_pending.sv
module irqmap_pending #(
   parameter int NREQ = 8,
   parameter int LW   = 4,
   parameter logic [NREQ*LW-1:0] LVL_MAP = 32'hE0A8_6410
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic [NREQ-1:0] req_i,
   output logic [NREQ-1:0] pend_d_o,
   output logic [NREQ-1:0] pend_q_o
);
   logic [NREQ-1:0] live_mask;

   for (genvar i = 0; i < NREQ; i++) begin : g_live
      if (LVL_MAP[i*LW +: LW] == '0) begin : g_dead
         assign live_mask[i] = 1'b0;
      end else begin : g_used
         assign live_mask[i] = 1'b1;
      end
   end

   assign pend_d_o = req_i & live_mask;

   always_ff @(posedge clk_i) begin
      if (rst_i) pend_q_o <= '0;
      else       pend_q_o <= pend_d_o;
   end
endmodule

// File: rtl/irqmap_level_fold.sv
module irqmap_level_fold #(
   parameter int NREQ = 8,
   parameter int NLVL = 16,
   parameter int LW   = 4,
   parameter logic [NREQ*LW-1:0] LVL_MAP = 32'hE0A8_6410
) (
   input  logic [NREQ-1:0] pend_i,
   input  logic            en_i,
   output logic [NLVL-1:0] lvl_o
);
   for (genvar l = 0; l < NLVL; l++) begin : g_lvl
      logic [NREQ-1:0] hits;
      for (genvar i = 0; i < NREQ; i++) begin : g_src
         if (l != 0 && int'(LVL_MAP[i*LW +: LW]) == l) begin : g_on
            assign hits[i] = pend_i[i];
         end else begin : g_off
            assign hits[i] = 1'b0;
         end
      end
      assign lvl_o[l] = en_i & (|hits);
   end
endmodule

// File: rtl/irq_level_mapper.sv
module irq_level_mapper
   import irqmap_pkg::*;
#(
   parameter int NREQ = 8,
   parameter int NLVL = 16,
   parameter int DW   = 8,
   parameter int EN_BIT = 0,
   parameter logic [NREQ*4-1:0] LVL_MAP = DEF_LVL_MAP,
   parameter logic [DW-1:0] WMASK   = DEF_WMASK,
   parameter logic [DW-1:0] CTRL_RST = DEF_CTRL_RST,
   parameter out_style_e OUT_STYLE = OUT_FLOP
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic [NREQ-1:0] irq_req_i,
   input  logic            reg_sel_i,
   input  logic            reg_we_i,
   input  logic [DW-1:0]   reg_wdata_i,
   output logic [DW-1:0]   reg_rdata_o,
   output logic [NLVL-1:0] level_o,
   output logic [NREQ-1:0] pending_o
);
   localparam int LW = 4;

   if (NLVL > (1 << LW)) begin : g_chk_lvl
      $error("NLVL exceeds table entry range");
   end
   if (EN_BIT >= DW) begin : g_chk_en
      $error("EN_BIT outside control byte");
   end
   for (genvar i = 0; i < NREQ; i++) begin : g_chk_map
      if (int'(LVL_MAP[i*LW +: LW]) >= NLVL) begin : g_bad
         $error("level table entry out of range");
      end
   end

   logic [DW-1:0]   ctrl_d, ctrl_q;
   logic [NREQ-1:0] pend_d, pend_q;

   irqmap_ctrl_reg #(.DW(DW), .WMASK(WMASK), .RST_VAL(CTRL_RST)) u_ctrl (
      .clk_i(clk_i), .rst_i(rst_i), .sel_i(reg_sel_i), .we_i(reg_we_i),
      .wdata_i(reg_wdata_i), .ctrl_d_o(ctrl_d), .ctrl_q_o(ctrl_q));

   irqmap_pending #(.NREQ(NREQ), .LW(LW), .LVL_MAP(LVL_MAP)) u_pend (
      .clk_i(clk_i), .rst_i(rst_i), .req_i(irq_req_i),
      .pend_d_o(pend_d), .pend_q_o(pend_q));

   if (OUT_STYLE == OUT_FLOP) begin : g_flop_out
      logic [NLVL-1:0] lvl_next, lvl_q;
      irqmap_level_fold #(.NREQ(NREQ), .NLVL(NLVL), .LW(LW), .LVL_MAP(LVL_MAP)) u_fold (
         .pend_i(pend_d), .en_i(ctrl_d[EN_BIT]), .lvl_o(lvl_next));
      always_ff @(posedge clk_i) begin
         if (rst_i) lvl_q <= '0;
         else       lvl_q <= lvl_next;
      end
      assign level_o = lvl_q;
   end else begin : g_comb_out
      irqmap_level_fold #(.NREQ(NREQ), .NLVL(NLVL), .LW(LW), .LVL_MAP(LVL_MAP)) u_fold (
         .pend_i(pend_q), .en_i(ctrl_q[EN_BIT]), .lvl_o(level_o));
   end

   assign reg_rdata_o = ctrl_q;
   assign pending_o   = pend_q;
endmodule

// File: rtl/irqmap_checker.sv
module irqmap_checker #(
   parameter int NREQ = 8,
   parameter int NLVL = 16,
   parameter int DW   = 8,
   parameter int EN_BIT = 0,
   parameter logic [NREQ*4-1:0] LVL_MAP = 32'hE0A8_6410,
   parameter logic [DW-1:0] WMASK = 8'hBF
) (
   input logic            clk_i,
   input logic            rst_i,
   input logic [NREQ-1:0] irq_req_i,
   input logic            reg_sel_i,
   input logic            reg_we_i,
   input logic [DW-1:0]   reg_wdata_i,
   input logic [DW-1:0]   reg_rdata_o,
   input logic [NLVL-1:0] level_o,
   input logic [NREQ-1:0] pending_o
);
   logic armed;
   always_ff @(posedge clk_i) begin
      if (rst_i) armed <= 1'b0;
      else       armed <= 1'b1;
   end

   function automatic logic [NREQ-1:0] live_of();
      logic [NREQ-1:0] m = '0;
      for (int i = 0; i < NREQ; i++) m[i] = (LVL_MAP[i*4 +: 4] != 4'd0);
      return m;
   endfunction

   function automatic logic [NLVL-1:0] spread(input logic [NREQ-1:0] p);
      logic [NLVL-1:0] r = '0;
      for (int i = 0; i < NREQ; i++)
         if (p[i]) r[LVL_MAP[i*4 +: 4]] = 1'b1;
      return r;
   endfunction

   assert_pending_follow_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      armed |-> pending_o == ($past(irq_req_i) & live_of()));

   assert_level0_silent_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      !level_o[0]);

   assert_level_union_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      armed && reg_rdata_o[EN_BIT] |-> level_o == spread(pending_o));

   assert_disable_gates_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      !reg_rdata_o[EN_BIT] |-> level_o == '0);

   assert_write_masked_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      armed && $past(reg_sel_i && reg_we_i) |-> reg_rdata_o == ($past(reg_wdata_i) & WMASK));

   assert_unselected_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      armed && !$past(reg_sel_i) |-> reg_rdata_o == $past(reg_rdata_o));
endmodule

bind irq_level_mapper irqmap_checker #(
   .NREQ(NREQ), .NLVL(NLVL), .DW(DW), .EN_BIT(EN_BIT),
   .LVL_MAP(LVL_MAP), .WMASK(WMASK)
) u_irqmap_chk (
   .clk_i(clk_i), .rst_i(rst_i), .irq_req_i(irq_req_i),
   .reg_sel_i(reg_sel_i), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
   .reg_rdata_o(reg_rdata_o), .level_o(level_o), .pending_o(pending_o));

// File: tb/tb_irq_level_mapper.sv
`timescale 1ns/1ps
module tb_irq_level_mapper;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  req = '0;
   logic        sel = 1'b0, we = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [15:0] lvl;
   logic [7:0]  pend;

   always #4 clk = ~clk;

   irq_level_mapper dut (
      .clk_i(clk), .rst_i(rst), .irq_req_i(req), .reg_sel_i(sel),
      .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .level_o(lvl), .pending_o(pend));

   int table_lvl [8] = '{0, 1, 4, 6, 8, 10, 0, 14};
   int n_cmp = 0, n_bad = 0;
   bit started = 0, finished = 0;

   // behavioural reference
   int m_ctrl = 1, m_pend = 0, m_lvl = 0;
   always @(posedge clk) begin
      if (rst) begin
         m_ctrl = 1; m_pend = 0; m_lvl = 0;
      end else begin
         if (sel && we) m_ctrl = int'(wdata) & 'hBF;
         m_pend = 0;
         for (int i = 0; i < 8; i++)
            if (req[i] && table_lvl[i] != 0) m_pend = m_pend | (1 << i);
         m_lvl = 0;
         if (m_ctrl % 2 == 1)
            for (int i = 0; i < 8; i++)
               if ((m_pend >> i) % 2 == 1) m_lvl = m_lvl | (1 << table_lvl[i]);
      end
      started = 1;
   end

   task automatic check(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (started && !finished) begin
      check("R1 R2 model pending", int'(pend), m_pend);
      check("R3 R4 R5 R9 model levels", int'(lvl), m_lvl);
      check("R6 R7 model readback", int'(rdata), m_ctrl);
   end

   task automatic drive(logic [7:0] r, logic s, logic w, logic [7:0] d);
      @(posedge clk); #1;
      req = r; sel = s; we = w; wdata = d;
   endtask

   // drive, let one edge sample it, drop the strobe, then look
   task automatic apply(logic [7:0] r, logic s, logic w, logic [7:0] d);
      drive(r, s, w, d);
      @(posedge clk); #1;
      sel = 0; we = 0;
      @(negedge clk);
   endtask

   task automatic finish_run();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 0;
      @(negedge clk);
      check("R8 reset ctrl", int'(rdata), 'h01);
      check("R8 reset pending", int'(pend), 0);
      check("R8 reset levels", int'(lvl), 0);

      // single-position walk
      for (int i = 0; i < 8; i++) begin
         apply(8'(1 << i), 0, 0, 0);
         if (table_lvl[i] == 0) begin
            check("R2 dead position levels", int'(lvl), 0);
            check("R2 dead position pending", int'(pend), 0);
         end else begin
            check("R3 single level", int'(lvl), 1 << table_lvl[i]);
            check("R1 single pending", int'(pend), 1 << i);
         end
      end

      apply(8'hBE, 0, 0, 0);
      check("R4 union levels", int'(lvl), 'h4552);
      apply(8'hFF, 0, 0, 0);
      check("R4 all-ones levels", int'(lvl), 'h4552);
      check("R2 all-ones pending", int'(pend), 'hBE);
      apply(8'h24, 0, 0, 0);
      check("R4 mixed levels", int'(lvl), 'h0410);

      apply(8'hFF, 1, 1, 8'h00);
      check("R5 disabled levels", int'(lvl), 0);
      check("R5 disabled pending", int'(pend), 'hBE);
      apply(8'h08, 0, 0, 0);
      check("R5 pending while disabled", int'(pend), 'h08);
      apply(8'h08, 1, 1, 8'h01);
      check("R5 re-enabled levels", int'(lvl), 'h0040);

      apply(8'h08, 1, 1, 8'hFF);
      check("R6 masked write", int'(rdata), 'hBF);
      apply(8'h08, 1, 1, 8'h40);
      check("R6 bit6 only write", int'(rdata), 'h00);
      check("R7 readback levels off", int'(lvl), 0);
      apply(8'h08, 0, 1, 8'h01);
      check("R9 unselected write", int'(rdata), 'h00);
      apply(8'h08, 1, 1, 8'h81);
      check("R7 readback", int'(rdata), 'h81);

      // latency: nothing before the sampling edge
      drive(8'h80, 0, 0, 0);
      @(negedge clk);
      check("R9 before edge", int'(lvl), 'h0040);
      @(negedge clk);
      check("R9 after edge", int'(lvl), 'h4000);
      apply(8'h00, 0, 0, 0);
      check("R1 released", int'(pend), 0);

      // pseudo-random interleaving, checked each clock by the model
      for (int k = 0; k < 3000; k++) begin
         drive(8'($urandom), ($urandom % 5) == 0, ($urandom % 2) == 0, 8'($urandom));
      end
      drive(8'h00, 0, 0, 0);
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule